// File: doc/BRIEF.md
# Dual-Mode Look-Ahead FIFO

This block is a first-in first-out buffer that joins two independent clock domains. Words are written on the write clock and read on the read clock. The buffer sits between a producer and a consumer that run at unrelated rates. Its depth and word width are parameters, and the depth must be a power of two. Each pointer crosses into the other domain as Gray code through a two-flop synchroniser. The flags that depend on the far side are therefore pessimistic: they may clear late, but they never clear early.

An operating mode is taken from a select pin while master reset is held low. In standard mode the consumer must issue a read strobe to move each word onto the output. The two status pins then report full and empty, both active low. In look-ahead mode the oldest word moves onto the output by itself. The same two pins then report input-ready and output-ready, both active low. The word held in the output register counts toward fullness in this mode, so one extra word fits. A partial reset empties the buffer and keeps the mode.

Back-pressure rules are the same at both ports. The producer may drive `wen_n` low at any time, but a word is taken only at a rising `wclk` edge where `wr_stat` shows space. The consumer may drive `ren_n` low at any time, but a word is consumed only at a rising `rclk` edge where `rd_stat` shows data. Any other strobe is dropped.

Top module: `dual_mode_fifo`

## Requirements
- R1: The mode is sampled from `look_sel` on rising edges of both clocks while `mrs_n` is low (0 = standard, 1 = look-ahead). After `mrs_n` returns high, changes on `look_sel` and partial resets leave the mode unchanged.
- R2: In standard mode `wr_stat` is 1 after reset and whenever space exists. With no reads, it falls to 0 at the rising `wclk` edge that takes the DEPTH-th word.
- R3: A write strobe at a `wclk` edge where the buffer is full is dropped. The write pointer does not move, and the dropped word never reaches `dout`.
- R4: In look-ahead mode `wr_stat` is 0 after reset and whenever space exists. With no reads, and once the first word has reached the output register, it rises to 1 at the `wclk` edge that takes the (DEPTH+1)-th word.
- R5: In standard mode `rd_stat` is 0 while empty and 1 while data is held. A read at a rising `rclk` edge puts the oldest word on `dout` just after that edge. `rd_stat` falls to 0 at the edge of the read that takes the last word.
- R6: In standard mode a read strobe while `rd_stat` is 0 is dropped, and `dout` keeps its previous value.
- R7: In look-ahead mode, the first word written to an empty buffer appears on `dout` with `rd_stat` at 0, with no read strobe. This happens at most 3 rising `rclk` edges after the write edge.
- R8: In look-ahead mode, while `rd_stat` is 0, `dout` holds its word until a read at a rising `rclk` edge. That read brings the next word, or, if none is stored, sets `rd_stat` to 1 while `dout` keeps the last word.
- R9: A low pulse on `prs_n` empties the buffer. Afterwards the status pins show empty and not-full in the current mode, and no stale word is ever output.
- R10: Under any interleaving of reads and writes in either mode, words leave in write order with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrs_n | input | 1 | Master reset, active low, asynchronous assert; mode is sampled while low |
| prs_n | input | 1 | Partial reset, active low; clears pointers and keeps the mode |
| look_sel | input | 1 | Mode select sampled during master reset (1 = look-ahead) |
| wen_n | input | 1 | Write strobe, active low |
| din | input | W | Write data |
| ren_n | input | 1 | Read strobe, active low |
| dout | output | W | Read data register |
| wr_stat | output | 1 | Full (standard, low = full) or input-ready (look-ahead, low = space) |
| rd_stat | output | 1 | Empty (standard, low = empty) or output-ready (look-ahead, low = data valid) |

## Verification
Results in a port's own domain are due at the clock edge of the access itself. `wr_stat` after a write edge and `dout`/`rd_stat` after a read edge are sampled at the very next falling edge of that same clock. Results that cross domains are due within three rising edges of the receiving clock: `rd_stat` after a write, the look-ahead word landing on `dout`, and `wr_stat` clearing after reads. The bench waits four or more receiving-clock edges before checking those. In the random phases, acceptance of a strobe is judged from the status pin sampled on the falling edge before the active edge, and the pin cannot change in between.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_LOOK = 1'b1
  } dmf_mode_e;
endpackage

// File: rtl/dmf_gray_sync.sv
module dmf_gray_sync #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  always_comb begin
    bin_out[PW-1] = stage2[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      bin_out[i] = bin_out[i+1] ^ stage2[i];
    end
  end
endmodule

// File: rtl/dmf_mem.sv
module dmf_mem #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dmf_wr_ctl.sv
module dmf_wr_ctl
  import dmf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  dmf_mode_e     mode,
  input  logic          wen_n,
  input  logic [PW-1:0] rbin_sync,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          wr_stat
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [PW-1:0] wbin, wbin_nx;
  logic          full_q;

  assign we      = !wen_n && !full_q;
  assign wbin_nx = wbin + {{AW{1'b0}}, we};
  assign waddr   = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      full_q <= 1'b0;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wbin_nx ^ (wbin_nx >> 1);
      full_q <= (wbin_nx - rbin_sync) == FULL_CNT;
    end
  end

  // standard: low means full; look-ahead: low means space
  assign wr_stat = (mode == MODE_LOOK) ? full_q : !full_q;

  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    (wbin - rbin_sync) <= FULL_CNT);

  p_full_blocks_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    (full_q && !wen_n) |=> $stable(wbin));
endmodule

// File: rtl/dmf_rd_ctl.sv
module dmf_rd_ctl
  import dmf_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  dmf_mode_e     mode,
  input  logic          ren_n,
  input  logic [PW-1:0] wbin_sync,
  input  logic [W-1:0]  mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic [W-1:0]  dout,
  output logic          rd_stat
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [PW-1:0] rbin, rbin_nx;
  logic          empty_q, out_valid, mem_ne, load;

  assign mem_ne = (rbin != wbin_sync);
  assign load   = (mode == MODE_LOOK) ? (mem_ne && (!out_valid || !ren_n))
                                      : (!ren_n && !empty_q);
  assign rbin_nx = rbin + {{AW{1'b0}}, load};
  assign raddr   = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      empty_q   <= 1'b1;
      out_valid <= 1'b0;
      dout      <= '0;
    end else begin
      rbin    <= rbin_nx;
      rgray   <= rbin_nx ^ (rbin_nx >> 1);
      empty_q <= (rbin_nx == wbin_sync);
      if (load) begin
        dout      <= mem_rdata;
        out_valid <= 1'b1;
      end else if (!ren_n) begin
        out_valid <= 1'b0;
      end
    end
  end

  // standard: low means empty; look-ahead: low means word valid
  assign rd_stat = (mode == MODE_LOOK) ? !out_valid : !empty_q;

  p_no_underrun_r10: assert property (@(posedge rclk) disable iff (!rst_n)
    (wbin_sync - rbin) <= FULL_CNT);

  p_empty_read_ignored_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    (mode == MODE_STD && empty_q && !ren_n) |=> ($stable(rbin) && $stable(dout)));

  p_hold_until_read_r8: assert property (@(posedge rclk) disable iff (!rst_n)
    (mode == MODE_LOOK && out_valid && ren_n) |=> (out_valid && $stable(dout)));
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import dmf_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         mrs_n,
  input  logic         prs_n,
  input  logic         look_sel,
  input  logic         wen_n,
  input  logic [W-1:0] din,
  input  logic         ren_n,
  output logic [W-1:0] dout,
  output logic         wr_stat,
  output logic         rd_stat
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic            rst_n;
  dmf_mode_e       mode_w, mode_r;
  logic            we;
  logic [AW-1:0]   waddr, raddr;
  logic [PW-1:0]   wgray, rgray, wbin_sync, rbin_sync;
  logic [W-1:0]    mem_rdata;

  assign rst_n = mrs_n && prs_n;

  // mode copies, one per domain, loaded only while master reset is held
  always_ff @(posedge wclk) begin
    if (!mrs_n) mode_w <= dmf_mode_e'(look_sel);
  end

  always_ff @(posedge rclk) begin
    if (!mrs_n) mode_r <= dmf_mode_e'(look_sel);
  end

  dmf_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
    .raddr(raddr), .rdata(mem_rdata)
  );

  dmf_gray_sync #(.PW(PW)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rbin_sync)
  );

  dmf_gray_sync #(.PW(PW)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wbin_sync)
  );

  dmf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .mode(mode_w), .wen_n(wen_n),
    .rbin_sync(rbin_sync), .we(we), .waddr(waddr), .wgray(wgray),
    .wr_stat(wr_stat)
  );

  dmf_rd_ctl #(.W(W), .DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .mode(mode_r), .ren_n(ren_n),
    .wbin_sync(wbin_sync), .mem_rdata(mem_rdata), .raddr(raddr),
    .rgray(rgray), .dout(dout), .rd_stat(rd_stat)
  );

  p_mode_stable_r1: assert property (@(posedge wclk) disable iff (!mrs_n)
    $past(mrs_n) |-> $stable(mode_w));
endmodule

// File: tb/dual_mode_fifo_bench.sv
module dual_mode_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int W = 16;
  localparam int DEPTH = 16;

  logic wclk = 0, rclk = 0;
  logic mrs_n = 0, prs_n = 1, look_sel = 0, wen_n = 1, ren_n = 1;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic wr_stat, rd_stat;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  bit wdone;
  logic [W-1:0] q[$];

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  dual_mode_fifo #(.W(W), .DEPTH(DEPTH)) u_dual_mode_fifo (
    .wclk(wclk), .rclk(rclk), .mrs_n(mrs_n), .prs_n(prs_n),
    .look_sel(look_sel), .wen_n(wen_n), .din(din), .ren_n(ren_n),
    .dout(dout), .wr_stat(wr_stat), .rd_stat(rd_stat)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected status pin values computed from the mode
  function automatic logic space_val(input bit look);
    return look ? 1'b0 : 1'b1;
  endfunction
  function automatic logic data_val(input bit look);
    return look ? 1'b0 : 1'b1;
  endfunction

  task automatic do_mrs(input bit mode);
    @(negedge wclk);
    mrs_n = 0; look_sel = mode;
    repeat (4) @(posedge rclk);
    @(negedge wclk);
    mrs_n = 1;
    look_sel = ~mode;   // later changes must not matter (R1)
    repeat (2) @(negedge wclk);
  endtask

  task automatic wr(input logic [W-1:0] v);
    @(negedge wclk);
    wen_n = 0; din = v;
    @(posedge wclk);
    @(negedge wclk);
    wen_n = 1;
  endtask

  task automatic rd;
    @(negedge rclk);
    ren_n = 0;
    @(posedge rclk);
    @(negedge rclk);
    ren_n = 1;
  endtask

  task automatic rand_phase(input bit look, input int n_wr);
    wdone = 0;
    q.delete();
    fork
      begin
        for (int i = 0; i < n_wr; i++) begin
          @(negedge wclk);
          if ($urandom % 3 != 0) begin
            bit acc;
            logic [W-1:0] v;
            v = W'($urandom);
            acc = (wr_stat == space_val(look));
            wen_n = 0; din = v;
            @(posedge wclk);
            if (acc) q.push_back(v);
            @(negedge wclk);
            wen_n = 1;
          end
        end
        wdone = 1;
      end
      begin
        int idle = 0;
        while (!(wdone && q.size() == 0) && idle < 400) begin
          @(negedge rclk);
          if (look) begin
            if (rd_stat == data_val(look)) begin
              idle = 0;
              if (q.size() == 0) check(0, "R10 spurious word", 32'(dout), 0);
              else begin
                check(dout == q[0], "R10 look order", 32'(dout), 32'(q[0]));
                if ($urandom % 2 == 0) begin
                  ren_n = 0;
                  void'(q.pop_front());
                  @(posedge rclk);
                  #1 ren_n = 1;
                end
              end
            end else idle++;
          end else begin
            if ($urandom % 2 == 0) begin
              bit go;
              go = (rd_stat == data_val(look));
              ren_n = 0;
              @(posedge rclk);
              @(negedge rclk);
              ren_n = 1;
              if (go) begin
                idle = 0;
                if (q.size() == 0) check(0, "R10 spurious word", 32'(dout), 0);
                else begin
                  logic [W-1:0] e;
                  e = q.pop_front();
                  check(dout == e, "R10 std order", 32'(dout), 32'(e));
                end
              end else idle++;
            end
          end
        end
        check(q.size() == 0, "R10 all words drained", q.size(), 0);
      end
    join
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_mrs(0);
    // ---------- standard mode ----------
    check(wr_stat == 1'b1, "R2 reset wr_stat", wr_stat, 1);
    check(rd_stat == 1'b0, "R5 reset rd_stat", rd_stat, 0);
    for (int i = 0; i < DEPTH - 1; i++) wr(W'(16'h100 + i));
    check(wr_stat == 1'b1, "R2 not full at D-1", wr_stat, 1);
    wr(W'(16'h100 + DEPTH - 1));
    check(wr_stat == 1'b0, "R2 full at D writes", wr_stat, 0);
    wr(W'(16'hDEAD));
    check(wr_stat == 1'b0, "R3 stays full", wr_stat, 0);
    repeat (5) @(posedge rclk);
    @(negedge rclk);
    check(rd_stat == 1'b1, "R5 data held", rd_stat, 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd();
      check(dout == W'(16'h100 + i), "R5/R3 read data", 32'(dout), 32'(16'h100 + i));
    end
    check(rd_stat == 1'b0, "R5 empty after last read", rd_stat, 0);
    rd();
    check(dout == W'(16'h100 + DEPTH - 1), "R6 empty read holds dout", 32'(dout),
          32'(16'h100 + DEPTH - 1));
    check(rd_stat == 1'b0, "R6 still empty", rd_stat, 0);
    repeat (6) @(negedge wclk);
    check(wr_stat == 1'b1, "R1 standard polarity kept despite look_sel", wr_stat, 1);
    // partial reset
    for (int i = 0; i < 3; i++) wr(W'(16'h300 + i));
    repeat (5) @(posedge rclk);
    @(negedge wclk);
    prs_n = 0;
    repeat (3) @(posedge rclk);
    @(negedge wclk);
    prs_n = 1;
    repeat (5) @(posedge rclk);
    @(negedge rclk);
    check(rd_stat == 1'b0, "R9 empty after partial reset", rd_stat, 0);
    check(wr_stat == 1'b1, "R9 not full after partial reset", wr_stat, 1);
    wr(W'(16'h55));
    repeat (5) @(posedge rclk);
    rd();
    check(dout == W'(16'h55), "R9 no stale word", 32'(dout), 32'h55);
    rand_phase(0, 1500);

    // ---------- look-ahead mode ----------
    do_mrs(1);
    check(wr_stat == 1'b0, "R4 reset wr_stat", wr_stat, 0);
    check(rd_stat == 1'b1, "R7 reset rd_stat", rd_stat, 1);
    wr(W'(16'hA0));
    repeat (4) @(posedge rclk);
    @(negedge rclk);
    check(rd_stat == 1'b0, "R7 word valid without read", rd_stat, 0);
    check(dout == W'(16'hA0), "R7 first word on dout", 32'(dout), 32'hA0);
    for (int i = 1; i < DEPTH; i++) wr(W'(16'hA0 + i));
    check(wr_stat == 1'b0, "R4 space after D writes", wr_stat, 0);
    wr(W'(16'hA0 + DEPTH));
    check(wr_stat == 1'b1, "R4 full after D+1 writes", wr_stat, 1);
    repeat (4) @(posedge rclk);
    @(negedge rclk);
    check(dout == W'(16'hA0) && rd_stat == 1'b0, "R8 hold without read",
          32'(dout), 32'hA0);
    for (int k = 1; k <= DEPTH; k++) begin
      rd();
      check(dout == W'(16'hA0 + k), "R8 next word after read", 32'(dout),
            32'(16'hA0 + k));
    end
    rd();
    check(rd_stat == 1'b1, "R8 not ready after last read", rd_stat, 1);
    check(dout == W'(16'hA0 + DEPTH), "R8 last word kept", 32'(dout),
          32'(16'hA0 + DEPTH));
    rand_phase(1, 1500);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule